// File: doc/BRIEF.md
# Boundary Register Test-Mode Engine

This block holds the boundary register of a scan-testable bus device. The register has one cell for each data input and one for each data output. It runs on the test clock and is driven by per-cycle strobes from an external TAP controller: capture, shift, update and run/idle. An external instruction register supplies a five-bit opcode. The low four bits select the operation and the top bit is a parity bit chosen so that the opcode as a whole has an even number of ones.

When an opcode fails the parity check, or names no defined operation, the block acts as if the bypass instruction were loaded. The functional transceiver path then reaches the pins untouched. The test operations take over the output pins and build on the same cells:
- signature compression of the inputs into a linear-feedback shift register;
- pseudo-random patterns on the outputs;
- a binary up-count on the outputs;
- a combined compress-and-count mode;
- toggling of the outputs on every update while the inputs are still sampled;
- clamping of the outputs;
- floating of the outputs.

The surrounding TAP controller reads and loads the register serially through one data input and one data output.

Top module: `bsr_test_engine`

## Requirements
- R1: An opcode with an odd number of ones, or one whose low four bits exceed 9, behaves exactly as bypass (code 0): pins follow the core and tdo comes from the bypass bit.
- R2: In bypass (code 0) and sample (code 1), pin_out equals core_out and pin_oe equals core_oe in the same cycle, whatever the strobes do.
- R3: In a register-selected mode (codes 1, 2, 5, 6, 7, 8, 9), a capture cycle loads the input cells (bits N_IN-1..0) from pin_in and the output cells (upper bits) from the value then on pin_out.
- R4: In a register-selected mode, tdo shows cell 0. Each shift cycle moves every cell one place toward tdo and puts tdi into the top cell.
- R5: In every test mode (codes 2 to 9), pin_out shows the update stage and pin_oe is 1. In codes 1, 2, 5, 6, 7 and 8, an update cycle copies the output cells into the update stage.
- R6: Clamp (code 3) holds pin_out at the update stage with pin_oe at 1, ignores update strobes, and routes tdo through the bypass bit.
- R7: High-impedance (code 4) drives pin_oe to 0 and routes tdo through the bypass bit.
- R8: Signature mode (code 5): each run/idle cycle replaces the input cells with the next LFSR state of those cells XOR pin_in. The LFSR shifts toward the upper bit and feeds back the XOR of a fixed maximal-length tap set (bits 7, 5, 4, 3 for eight cells).
- R9: Pattern mode (code 6): each run/idle cycle advances the update stage by one step of the same kind of LFSR, so the pattern appears on pin_out.
- R10: Count mode (code 7): each run/idle cycle adds one to the update stage, wrapping from all ones to zero.
- R11: Combined mode (code 8): a run/idle cycle compresses the inputs as in R8 and counts the outputs as in R10 in the same cycle.
- R12: Toggle mode (code 9): each update cycle inverts the update stage, and capture still samples the inputs.
- R13: The bypass bit loads 0 on capture and tdi on shift.
- R14: An active-low asynchronous reset clears all cells, the update stage and the bypass bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Capture strobe from TAP controller |
| shift_en | input | 1 | Shift strobe from TAP controller |
| update_en | input | 1 | Update strobe from TAP controller |
| runidle_en | input | 1 | Run/idle strobe from TAP controller |
| tdi | input | 1 | Serial test data in |
| opcode | input | 5 | Instruction, {parity, code[3:0]} |
| pin_in | input | N_IN | Values seen at the data input pins |
| core_out | input | N_OUT | Functional output data from the core |
| core_oe | input | 1 | Functional output enable from the core |
| pin_out | output | N_OUT | Data driven toward the output pins |
| pin_oe | output | 1 | Output enable toward the pins |
| tdo | output | 1 | Serial test data out |

## Verification
A signature can only be seen by shifting the register out without a capture first, because a capture would overwrite the compressed cells. The stimulus therefore goes straight from run/idle cycles into a full-length shift. Pattern and count modes start from whatever the update stage holds, so each of those runs is first seeded through sample mode (shift then update), and then the opcode is switched. The count seed sits just below full scale so that the wrap falls inside a short run.

// File: rtl/bte_pkg.sv
package bte_pkg;
  localparam int OPC_W  = 5;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    M_BYPASS = 4'd0,
    M_SAMPLE = 4'd1,
    M_EXTEST = 4'd2,
    M_CLAMP  = 4'd3,
    M_HIGHZ  = 4'd4,
    M_PSA    = 4'd5,
    M_PRPG   = 4'd6,
    M_COUNT  = 4'd7,
    M_PSACNT = 4'd8,
    M_TOGGLE = 4'd9
  } mode_e;

  localparam logic [CODE_W-1:0] LAST_CODE = 4'd9;

  // Feedback tap mask of a maximal-length LFSR of width w (4..16).
  function automatic logic [31:0] lfsr_taps(input int w);
    case (w)
      4:  return 32'h0000_000C;
      5:  return 32'h0000_0014;
      6:  return 32'h0000_0030;
      7:  return 32'h0000_0060;
      8:  return 32'h0000_00B8;
      9:  return 32'h0000_0110;
      10: return 32'h0000_0240;
      11: return 32'h0000_0500;
      12: return 32'h0000_0E08;
      13: return 32'h0000_1C80;
      14: return 32'h0000_3802;
      15: return 32'h0000_6000;
      16: return 32'h0000_D008;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // One step: shift toward the upper bit, feedback into bit 0.
  function automatic logic [31:0] lfsr_next(input logic [31:0] s, input int w);
    logic fb;
    logic [31:0] keep;
    fb   = ^(s & lfsr_taps(w));
    keep = (32'h1 << w) - 32'h1;
    return ((s << 1) | {31'h0, fb}) & keep;
  endfunction
endpackage

// File: rtl/bte_decode.sv
module bte_decode
  import bte_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output mode_e            mode,
  output logic             parity_ok,
  output logic             test_active,
  output logic             chain_sel
);
  logic [CODE_W-1:0] code;

  always_comb begin
    code      = opcode[CODE_W-1:0];
    parity_ok = ~^opcode;
    mode      = M_BYPASS;
    if (parity_ok && code <= LAST_CODE) mode = mode_e'(code);
  end

  always_comb begin
    test_active = !(mode == M_BYPASS || mode == M_SAMPLE);
    chain_sel   = !(mode == M_BYPASS || mode == M_CLAMP || mode == M_HIGHZ);
  end
endmodule

// File: rtl/bte_chain.sv
module bte_chain
  import bte_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             sel,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             compress_en,
  input  logic             tdi,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] drive_val,
  output logic             chain_lsb,
  output logic [N_OUT-1:0] out_cells
);
  localparam int LEN = N_IN + N_OUT;

  logic [LEN-1:0]  cells;
  logic [N_IN-1:0] sig_next;

  always_comb sig_next = N_IN'(lfsr_next(32'(cells[N_IN-1:0]), N_IN)) ^ pin_in;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                  cells <= '0;
    else if (sel && capture_en)   cells <= {drive_val, pin_in};
    else if (sel && shift_en)     cells <= {tdi, cells[LEN-1:1]};
    else if (compress_en)         cells[N_IN-1:0] <= sig_next;
  end

  assign chain_lsb = cells[0];
  assign out_cells = cells[LEN-1:N_IN];
endmodule

// File: rtl/bte_update.sv
module bte_update
  import bte_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             load_en,
  input  logic             toggle_mode,
  input  logic             prpg_step,
  input  logic             count_step,
  input  logic [N_OUT-1:0] load_val,
  output logic [N_OUT-1:0] upd
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          upd <= '0;
    else if (load_en)     upd <= toggle_mode ? ~upd : load_val;
    else if (prpg_step)   upd <= N_OUT'(lfsr_next(32'(upd), N_OUT));
    else if (count_step)  upd <= upd + N_OUT'(1);
  end
endmodule

// File: rtl/bsr_test_engine.sv
module bsr_test_engine
  import bte_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8
) (
  input  logic                   tck,
  input  logic                   trst_n,
  input  logic                   capture_en,
  input  logic                   shift_en,
  input  logic                   update_en,
  input  logic                   runidle_en,
  input  logic                   tdi,
  input  logic [bte_pkg::OPC_W-1:0] opcode,
  input  logic [N_IN-1:0]        pin_in,
  input  logic [N_OUT-1:0]       core_out,
  input  logic                   core_oe,
  output logic [N_OUT-1:0]       pin_out,
  output logic                   pin_oe,
  output logic                   tdo
);
  mode_e            mode;
  logic             parity_ok, test_active, chain_sel;
  logic             chain_lsb, byp_q;
  logic [N_OUT-1:0] out_cells, upd;
  logic             compress_evt, prpg_evt, count_evt, load_evt;

  bte_decode u_dec (
    .opcode(opcode), .mode(mode), .parity_ok(parity_ok),
    .test_active(test_active), .chain_sel(chain_sel)
  );

  // Named internal events
  assign compress_evt = runidle_en && (mode == M_PSA || mode == M_PSACNT);
  assign prpg_evt     = runidle_en && (mode == M_PRPG);
  assign count_evt    = runidle_en && (mode == M_COUNT || mode == M_PSACNT);
  assign load_evt     = update_en && chain_sel;

  bte_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chain (
    .tck(tck), .trst_n(trst_n), .sel(chain_sel),
    .capture_en(capture_en), .shift_en(shift_en), .compress_en(compress_evt),
    .tdi(tdi), .pin_in(pin_in), .drive_val(pin_out),
    .chain_lsb(chain_lsb), .out_cells(out_cells)
  );

  bte_update #(.N_OUT(N_OUT)) u_upd (
    .tck(tck), .trst_n(trst_n), .load_en(load_evt),
    .toggle_mode(mode == M_TOGGLE), .prpg_step(prpg_evt),
    .count_step(count_evt), .load_val(out_cells), .upd(upd)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         byp_q <= 1'b0;
    else if (capture_en) byp_q <= 1'b0;
    else if (shift_en)   byp_q <= tdi;
  end

  always_comb begin
    pin_out = test_active ? upd : core_out;
    pin_oe  = test_active ? (mode != M_HIGHZ) : core_oe;
    tdo     = chain_sel ? chain_lsb : byp_q;
  end
endmodule

// File: rtl/bte_checker.sv
module bte_checker
  import bte_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input logic             tck,
  input logic             trst_n,
  input logic             capture_en,
  input logic             shift_en,
  input logic             update_en,
  input logic             runidle_en,
  input logic             tdi,
  input logic [OPC_W-1:0] opcode,
  input logic [N_OUT-1:0] core_out,
  input logic             core_oe,
  input logic [N_OUT-1:0] pin_out,
  input logic             pin_oe,
  input logic             tdo,
  input mode_e            mode,
  input logic             test_active,
  input logic             chain_sel
);
  a_r1_bad_parity_idle: assert property (@(posedge tck) disable iff (!trst_n)
    (^opcode) |-> (!test_active && !chain_sel));

  a_r2_normal_path: assert property (@(posedge tck) disable iff (!trst_n)
    !test_active |-> (pin_out == core_out && pin_oe == core_oe));

  a_r7_highz_float: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == M_HIGHZ) |-> !pin_oe);

  a_r6_clamp_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == M_CLAMP && $past(mode == M_CLAMP)) |-> $stable(pin_out));

  a_r10_count_step: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == M_COUNT && runidle_en && !update_en)
      |=> (!test_active || pin_out == N_OUT'($past(pin_out) + N_OUT'(1))));

  a_r12_toggle_flip: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == M_TOGGLE && update_en) |=> (!test_active || pin_out == ~$past(pin_out)));

  a_r13_bypass_shift: assert property (@(posedge tck) disable iff (!trst_n)
    (!chain_sel && shift_en && !capture_en) |=> (chain_sel || tdo == $past(tdi)));
endmodule

bind bsr_test_engine bte_checker #(.N_OUT(N_OUT)) u_chk (
  .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
  .update_en(update_en), .runidle_en(runidle_en), .tdi(tdi), .opcode(opcode),
  .core_out(core_out), .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe),
  .tdo(tdo), .mode(mode), .test_active(test_active), .chain_sel(chain_sel)
);

// File: tb/sim_bsr_test_engine.sv
`timescale 1ns/1ps
module sim_bsr_test_engine;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       capture_en = 0, shift_en = 0, update_en = 0, runidle_en = 0, tdi = 0;
  logic [4:0] opcode = 5'd0;
  logic [7:0] pin_in = 8'h00, core_out = 8'h00;
  logic       core_oe = 1'b0;
  logic [7:0] pin_out;
  logic       pin_oe, tdo;

  int errors = 0, checks = 0;
  string cur_req = "R14";

  // reference model state
  int m_chain = 0;   // 16 bits: [7:0] input cells, [15:8] output cells
  int m_upd = 0;
  int m_byp = 0;

  always #2 tck = ~tck;

  bsr_test_engine u0 (
    .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .runidle_en(runidle_en), .tdi(tdi), .opcode(opcode),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .tdo(tdo)
  );

  function automatic int bmode(input logic [4:0] op);
    int ones = 0;
    for (int i = 0; i < 5; i++) ones += op[i];
    if (ones % 2 != 0) return 0;
    if (op[3:0] > 9) return 0;
    return op[3:0];
  endfunction

  function automatic int step8(input int s);
    int fb;
    fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
    return ((s * 2) % 256) + fb;
  endfunction

  function automatic bit is_test(input int m);  return m >= 2; endfunction
  function automatic bit is_sel(input int m);   return !(m == 0 || m == 3 || m == 4); endfunction

  function automatic int exp_pin(input int m);
    return is_test(m) ? m_upd : int'(core_out);
  endfunction

  task automatic model_edge();
    int m, drv, old_chain;
    m = bmode(opcode);
    drv = exp_pin(m);
    old_chain = m_chain;
    if (is_sel(m) && capture_en)      m_chain = drv * 256 + pin_in;
    else if (is_sel(m) && shift_en)   m_chain = (m_chain / 2) + (tdi ? 32768 : 0);
    else if (runidle_en && (m == 5 || m == 8))
      m_chain = (m_chain & 16'hFF00) | (step8(m_chain & 255) ^ int'(pin_in));
    if (is_sel(m) && update_en)       m_upd = (m == 9) ? (255 - m_upd) : (old_chain / 256);
    else if (runidle_en && m == 6)    m_upd = step8(m_upd);
    else if (runidle_en && (m == 7 || m == 8)) m_upd = (m_upd + 1) % 256;
    if (capture_en)    m_byp = 0;
    else if (shift_en) m_byp = tdi;
  endtask

  task automatic check_outputs();
    int m, e_pin, e_oe, e_tdo;
    m = bmode(opcode);
    e_pin = exp_pin(m);
    e_oe  = is_test(m) ? (m != 4) : core_oe;
    e_tdo = is_sel(m) ? (m_chain & 1) : m_byp;
    checks++;
    if (pin_out !== e_pin[7:0] || pin_oe !== e_oe[0] || tdo !== e_tdo[0]) begin
      errors++;
      $display("FAIL %s: pin_out=%h oe=%b tdo=%b expected pin_out=%h oe=%0d tdo=%0d",
               cur_req, pin_out, pin_oe, tdo, e_pin[7:0], e_oe, e_tdo);
    end
  endtask

  task automatic tick(input bit c, input bit s, input bit u, input bit r, input bit t);
    capture_en = c; shift_en = s; update_en = u; runidle_en = r; tdi = t;
    @(posedge tck);
    model_edge();
    @(negedge tck);
    check_outputs();
  endtask

  task automatic set_op(input int code, input bit bad_par);
    logic [3:0] c;
    c = code[3:0];
    opcode = {(^c) ^ bad_par, c};
    #0.1;
    check_outputs();
  endtask

  task automatic shift16(input int val);
    for (int i = 0; i < 16; i++) tick(0, 1, 0, 0, val[i]);
  endtask

  // Preload the update stage with seed via sample mode (R5 load path)
  task automatic seed(input int val);
    set_op(1, 0);
    shift16(val * 256);
    tick(0, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    opcode = {1'b1, 4'd2};   // extest with good parity during reset
    core_out = 8'h5A; core_oe = 1'b0;
    repeat (3) @(negedge tck);
    cur_req = "R14";
    check_outputs();
    trst_n = 1'b1;
    tick(0, 0, 0, 0, 0);

    // R2: normal path while strobes toggle
    cur_req = "R2";
    set_op(0, 0);
    for (int i = 0; i < 6; i++) begin
      core_out = 8'(i * 37 + 3); core_oe = i[0];
      tick(i == 1, i == 2, i == 3, i == 4, i[1]);
    end
    set_op(1, 0);
    core_out = 8'hC3; core_oe = 1;
    tick(0, 0, 0, 1, 0);

    // R13: bypass bit
    cur_req = "R13";
    set_op(0, 0);
    tick(1, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) tick(0, 1, 0, 0, (i % 3) == 0);

    // R3 / R4: capture in sample mode and shift out
    cur_req = "R3";
    set_op(1, 0);
    pin_in = 8'hA7; core_out = 8'h3C;
    tick(1, 0, 0, 0, 0);
    cur_req = "R4";
    shift16(16'h9E21);

    // R5: extest load and drive
    cur_req = "R5";
    set_op(2, 0);
    shift16(16'h6D00);
    tick(0, 0, 1, 0, 0);
    tick(1, 0, 0, 0, 0);
    shift16(16'h1200);

    // R6: clamp ignores update, tdo via bypass
    cur_req = "R6";
    set_op(3, 0);
    tick(0, 1, 0, 0, 1);
    tick(0, 0, 1, 0, 0);
    tick(1, 0, 0, 0, 0);

    // R7: high impedance
    cur_req = "R7";
    set_op(4, 0);
    tick(0, 1, 0, 0, 1);
    tick(0, 0, 1, 0, 0);

    // R1: bad parity and undefined code
    cur_req = "R1";
    set_op(2, 1);
    core_out = 8'h81; core_oe = 0;
    tick(0, 1, 0, 0, 1);
    tick(0, 0, 1, 0, 0);
    set_op(12, 0);
    tick(0, 1, 0, 0, 0);
    set_op(5, 1);
    tick(0, 0, 0, 1, 0);

    // R8: signature, read out without capture
    cur_req = "R8";
    set_op(5, 0);
    tick(1, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin
      pin_in = 8'(i * 29 + 11);
      tick(0, 0, 0, 1, 0);
    end
    shift16(0);

    // R9: pattern generation
    cur_req = "R9";
    seed(8'h01);
    set_op(6, 0);
    for (int i = 0; i < 30; i++) tick(0, 0, 0, 1, 0);

    // R10: count with wrap
    cur_req = "R10";
    seed(8'hFA);
    set_op(7, 0);
    for (int i = 0; i < 10; i++) tick(0, 0, 0, 1, 0);

    // R11: combined compress and count
    cur_req = "R11";
    seed(8'hFE);
    set_op(8, 0);
    tick(1, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      pin_in = 8'(255 - i * 13);
      tick(0, 0, 0, 1, 0);
    end
    shift16(0);

    // R12: toggle on update, capture still samples
    cur_req = "R12";
    seed(8'h35);
    set_op(9, 0);
    for (int i = 0; i < 3; i++) begin
      pin_in = 8'(i * 71 + 5);
      tick(0, 0, 1, 0, 0);
      tick(1, 0, 0, 0, 0);
    end
    shift16(16'h0F0F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule